// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer (SPI Host)

This block is the host side of a link to an eight-input, 8-bit serial successive-approximation converter. When a request arrives with an input selection, a single-ended/differential choice and a unipolar/bipolar choice, it builds the command byte and drops chip select. It then clocks three 8-bit full-duplex frames in SPI mode 0 (clock idle low, data sampled on the rising edge, data changed on the falling edge). The first frame carries the command and asks for external-clock conversion with the converter kept powered. The next two frames send zeros while the converter's reply is read back.

The 8-bit result sits inside the last sixteen received bits. It is preceded by two zero pad bits and followed by six more. The block extracts the result, checks that the two leading pad bits are zero, and checks that the time from the end of the command byte to the end of the readout stays within a parameterised cycle budget. The default budget is 1 ms of system clock. It returns the result, the two error flags and a one-cycle completion pulse. The serial clock rate is set at elaboration from the system clock and a target rate, which should lie between 50 kHz and 500 kHz.

Top module: `adc_conv_host`

## Requirements
- R1: After reset, chip select is high (`cs_n`=1), `sclk` is low, and `busy`, `done`, `result`, `frame_err` and `tmo_err` are all 0.
- R2: `sclk` is low whenever chip select is high. Each `sclk` high and low phase lasts HALF = CLK_HZ/(2·SCLK_HZ) system cycles, so a conversion holds `sclk` high for exactly 24·HALF cycles. `mosi` never changes while `sclk` is high.
- R3: The first byte sent, MSB first, is: bit 7 = 1, bits 6..4 = `chan`, bit 3 = `unipolar`, bit 2 = `single_end`, bits 1 and 0 = 1.
- R4: The second and third bytes sent are all zero.
- R5: Each accepted request lowers chip select once and produces exactly 24 rising `sclk` edges before chip select rises again.
- R6: Counting the last 16 received bits as 15 (first) down to 0, `result` equals bits 13..6. The 8 bits received during the command byte have no effect on any output.
- R7: `frame_err` is 1 exactly when either received bit 15 or bit 14 of that 16-bit field is 1. `result` is still extracted in that case.
- R8: `busy` rises on the cycle after an accepted `start` and stays high until chip select returns high. A `start` while `busy` is 1 is ignored and starts no new transfer.
- R9: `done` is a single-cycle pulse. It is asserted in the same cycle that chip select returns high, together with the new `result`, `frame_err` and `tmo_err`.
- R10: `tmo_err` is 1 when the span from the eighth falling `sclk` edge to the twenty-fourth exceeds TMO_CYC system cycles, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, sampled while idle |
| chan | input | 3 | Input channel selection code |
| single_end | input | 1 | 1 = single-ended input, 0 = differential pair |
| unipolar | input | 1 | 1 = unipolar coding, 0 = bipolar |
| miso | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data to the converter |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 8 | Extracted conversion code |
| frame_err | output | 1 | Leading pad bits were not zero |
| tmo_err | output | 1 | Readout exceeded the time budget |

## Verification
The assertions assume that `miso` only changes between `sclk` edges, as a mode-0 slave does on falling edges. They also assume the divider ratio HALF is at least 2. The bench's slave model updates `miso` only on falling `sclk` edges or at the chip-select fall, and both bench instances use ratios of 50 and 5. Requests are driven for one cycle away from the clock edge. The extra request used to probe the busy interlock is issued only while a transfer is in progress.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  localparam int SEL_W      = 3;
  localparam int CMD_BITS   = 8;
  localparam int FRAME_BITS = 24;
  localparam int RX_BITS    = 16;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_TAIL} host_state_t;

  // command layout: start, select, coding, input mode, keep-powered, ext clock
  function automatic logic [CMD_BITS-1:0] make_cmd(input logic [SEL_W-1:0] sel,
                                                   input logic uni, input logic se);
    return {1'b1, sel, uni, se, 1'b1, 1'b1};
  endfunction
endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
  parameter int HALF = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clear,
  output logic tick
);
  localparam int DW = $clog2(HALF) + 1;
  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear || !run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == DW'(HALF - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_shift_engine.sv
module adc_shift_engine
  import adc_host_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [CMD_BITS-1:0] cmd,
  input  logic                tick,
  input  logic                miso,
  output logic                sclk,
  output logic                mosi,
  output logic [9:0]          rx_head,
  output logic                cmd_end,
  output logic                frame_end
);
  logic [FRAME_BITS-1:0] tx;
  logic [RX_BITS-1:0]    rx;
  logic [CNT_W-1:0]      nfall;
  logic                  active;

  assign mosi    = tx[FRAME_BITS-1];
  assign rx_head = rx[RX_BITS-1:6];

  always_ff @(posedge clk) begin
    cmd_end   <= 1'b0;
    frame_end <= 1'b0;
    if (rst) begin
      tx <= '0; rx <= '0; nfall <= '0; active <= 1'b0; sclk <= 1'b0;
    end else if (load) begin
      tx     <= {cmd, {(FRAME_BITS-CMD_BITS){1'b0}}};
      rx     <= '0;
      nfall  <= '0;
      active <= 1'b1;
      sclk   <= 1'b0;
    end else if (tick && active) begin
      if (!sclk) begin
        sclk <= 1'b1;
        rx   <= {rx[RX_BITS-2:0], miso};
      end else begin
        sclk  <= 1'b0;
        tx    <= {tx[FRAME_BITS-2:0], 1'b0};
        nfall <= nfall + 1'b1;
        if (nfall == CNT_W'(CMD_BITS - 1)) cmd_end <= 1'b1;
        if (nfall == CNT_W'(FRAME_BITS - 1)) begin
          frame_end <= 1'b1;
          active    <= 1'b0;
        end
      end
    end
  end

  assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));
  assert_edge_bound_R5: assert property (@(posedge clk) disable iff (rst)
    nfall <= CNT_W'(FRAME_BITS));
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int TMO_CYC = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic arm,
  input  logic stop,
  output logic over
);
  localparam int TW = $clog2(TMO_CYC + 2);
  logic [TW-1:0] cnt;
  logic          on;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0; on <= 1'b0; over <= 1'b0;
    end else if (arm) begin
      cnt <= '0; on <= 1'b1;
    end else if (on) begin
      if (stop) on <= 1'b0;
      if (cnt != {TW{1'b1}}) cnt <= cnt + 1'b1;
      if (cnt >= TW'(TMO_CYC)) over <= 1'b1;
    end
  end

  assert_over_in_window_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(over) |-> $past(on));
endmodule

// File: rtl/adc_conv_host.sv
module adc_conv_host
  import adc_host_pkg::*;
#(
  parameter int CLK_HZ  = 50_000_000,
  parameter int SCLK_HZ = 500_000,
  parameter int TMO_CYC = CLK_HZ / 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [2:0] chan,
  input  logic       single_end,
  input  logic       unipolar,
  input  logic       miso,
  output logic       cs_n,
  output logic       sclk,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] result,
  output logic       frame_err,
  output logic       tmo_err
);
  localparam int HALF = CLK_HZ / (2 * SCLK_HZ);

  host_state_t st;
  logic        load, tick, cmd_end, frame_end, over;
  logic [9:0]  rx_head;

  assign load = (st == S_IDLE) && start;

  adc_sclk_div #(.HALF(HALF)) div_i (
    .clk(clk), .rst(rst), .run(st != S_IDLE), .clear(load), .tick(tick));

  adc_shift_engine eng_i (
    .clk(clk), .rst(rst), .load(load),
    .cmd(make_cmd(chan, unipolar, single_end)),
    .tick(tick), .miso(miso), .sclk(sclk), .mosi(mosi),
    .rx_head(rx_head), .cmd_end(cmd_end), .frame_end(frame_end));

  adc_conv_timer #(.TMO_CYC(TMO_CYC)) tmr_i (
    .clk(clk), .rst(rst), .clear(load), .arm(cmd_end), .stop(frame_end),
    .over(over));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; cs_n <= 1'b1; busy <= 1'b0; done <= 1'b0;
      result <= '0; frame_err <= 1'b0; tmo_err <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st <= S_XFER; cs_n <= 1'b0; busy <= 1'b1;
        end
        S_XFER: if (frame_end) st <= S_TAIL;
        S_TAIL: if (tick) begin
          st        <= S_IDLE;
          cs_n      <= 1'b1;
          busy      <= 1'b0;
          done      <= 1'b1;
          result    <= rx_head[7:0];
          frame_err <= |rx_head[9:8];
          tmo_err   <= over;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);
  assert_busy_origin_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_released_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (cs_n && !busy));
endmodule

// File: tb/adc_conv_host_tb_top.sv
module adc_slave_bfm (
  input  logic        cs_n,
  input  logic        sclk,
  input  logic        mosi,
  input  logic [23:0] reply,
  output logic        miso,
  output logic [23:0] got,
  output int          rises,
  output int          cs_falls
);
  logic        p_cs = 1'b1;
  logic        p_sclk = 1'b0;
  logic [23:0] sh = '0;
  initial begin miso = 1'b0; got = '0; rises = 0; cs_falls = 0; end

  always @(cs_n or sclk) begin
    if (p_cs && !cs_n) begin
      cs_falls = cs_falls + 1; rises = 0; got = '0;
      sh = reply; miso = reply[23];
    end else if (!cs_n && !p_sclk && sclk) begin
      got = {got[22:0], mosi}; rises = rises + 1;
    end else if (!cs_n && p_sclk && !sclk) begin
      sh = {sh[22:0], 1'b0}; miso = sh[23];
    end
    p_cs = cs_n; p_sclk = sclk;
  end
endmodule

module adc_conv_host_tb_top;
  localparam int HALF_M = 50;  // 50 MHz / (2 * 500 kHz)
  localparam int HALF_T = 5;   // 50 MHz / (2 * 5 MHz)

  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  int total = 0, bad = 0;

  // main instance
  logic start = 0, se = 0, uni = 0;
  logic [2:0] chan = 0;
  logic cs_n, sclk, mosi, busy, done, frame_err, tmo_err, miso;
  logic [7:0] result;
  logic [23:0] reply_m = '0, got_m;
  int rises_m, falls_m;

  adc_conv_host dut_i (
    .clk(clk), .rst(rst), .start(start), .chan(chan), .single_end(se),
    .unipolar(uni), .miso(miso), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .busy(busy), .done(done), .result(result), .frame_err(frame_err),
    .tmo_err(tmo_err));
  adc_slave_bfm slv_m (.cs_n(cs_n), .sclk(sclk), .mosi(mosi), .reply(reply_m),
    .miso(miso), .got(got_m), .rises(rises_m), .cs_falls(falls_m));

  // short-budget instance
  logic start_t = 0;
  logic cs_t, sclk_t, mosi_t, busy_t, done_t, ferr_t, terr_t, miso_t;
  logic [7:0] result_t;
  logic [23:0] reply_t = '0, got_t;
  int rises_t, falls_t;

  adc_conv_host #(.CLK_HZ(50_000_000), .SCLK_HZ(5_000_000), .TMO_CYC(100)) dut_tmo (
    .clk(clk), .rst(rst), .start(start_t), .chan(3'd5), .single_end(1'b1),
    .unipolar(1'b1), .miso(miso_t), .cs_n(cs_t), .sclk(sclk_t), .mosi(mosi_t),
    .busy(busy_t), .done(done_t), .result(result_t), .frame_err(ferr_t),
    .tmo_err(terr_t));
  adc_slave_bfm slv_t (.cs_n(cs_t), .sclk(sclk_t), .mosi(mosi_t), .reply(reply_t),
    .miso(miso_t), .got(got_t), .rises(rises_t), .cs_falls(falls_t));

  // port monitors for the main instance
  int hi_m = 0, mosi_bad = 0;
  logic p_sclk = 0, p_mosi = 0;
  always @(posedge clk) begin
    if (sclk) hi_m <= hi_m + 1;
    if (sclk && p_sclk && (mosi != p_mosi)) mosi_bad <= mosi_bad + 1;
    p_sclk <= sclk; p_mosi <= mosi;
  end

  function automatic logic [7:0] exp_cmd(input logic [2:0] c, input logic u, input logic s);
    return {1'b1, c, u, s, 2'b11};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic conv(input logic [2:0] c, input logic s, input logic u,
                      input logic [7:0] d, input logic [1:0] lead,
                      input logic [7:0] junk, input bit poke);
    int f0, h0, mb0, n;
    reply_m = {junk, lead, d, 6'b0};
    f0 = falls_m; h0 = hi_m; mb0 = mosi_bad;
    @(negedge clk); chan = c; se = s; uni = u; start = 1;
    @(negedge clk); start = 0;
    if (poke) begin
      repeat (300) @(negedge clk);
      chk(busy == 1'b1, "R8 busy mid-transfer", busy, 1);
      chan = ~c; se = ~s; uni = ~u; start = 1;
      @(negedge clk); start = 0; chan = c; se = s; uni = u;
    end
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk(done == 1'b1, "R9 done seen", done, 1);
    chk(cs_n == 1'b1 && busy == 1'b0, "R9 cs high with done", {cs_n, busy}, 2);
    chk(got_m[23:16] == exp_cmd(c, u, s), "R3 command byte", got_m[23:16], exp_cmd(c, u, s));
    chk(got_m[15:0] == 16'h0, "R4 zero fill bytes", got_m[15:0], 0);
    chk(rises_m == 24 && falls_m == f0 + 1, "R5 R8 one frame of 24", rises_m, 24);
    chk(result == d, "R6 result", result, d);
    chk(frame_err == (lead != 2'b00), "R7 frame_err", frame_err, lead != 2'b00);
    chk(tmo_err == 1'b0, "R10 no timeout", tmo_err, 0);
    chk(hi_m - h0 == 24 * HALF_M, "R2 sclk high cycles", hi_m - h0, 24 * HALF_M);
    chk(mosi_bad == mb0, "R2 mosi stable while sclk high", mosi_bad - mb0, 0);
    @(negedge clk);
    chk(done == 1'b0, "R9 done single cycle", done, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(cs_n && !sclk && !busy && !done, "R1 reset state", {cs_n, sclk, busy, done}, 8);
    chk(result == 8'h0 && !frame_err && !tmo_err, "R1 reset outputs", result, 0);
    chk(cs_t && !sclk_t, "R1 R2 reset idle clock", {cs_t, sclk_t}, 2);

    // directed corners
    conv(3'd0, 1'b1, 1'b1, 8'h00, 2'b00, 8'hFF, 0);
    conv(3'd7, 1'b0, 1'b0, 8'hFF, 2'b00, 8'h00, 0);
    conv(3'd3, 1'b1, 1'b0, 8'hA5, 2'b01, 8'h5A, 0);
    conv(3'd4, 1'b0, 1'b1, 8'h3C, 2'b10, 8'hC3, 0);
    conv(3'd2, 1'b1, 1'b1, 8'h81, 2'b00, 8'hFF, 1);
    // constrained random
    for (int i = 0; i < 10; i++) begin
      logic [31:0] r;
      r = $urandom;
      conv(r[2:0], r[3], r[4], r[12:5], (r[13:20] == 0) ? 2'b11 : 2'b00, r[31:24], 0);
    end

    // R10: readout span of 16*2*HALF_T = 160 cycles exceeds budget of 100
    reply_t = {8'hAA, 2'b00, 8'h6B, 6'b0};
    @(negedge clk); start_t = 1;
    @(negedge clk); start_t = 0;
    n = 0;
    while (!done_t && n < 2000) begin @(negedge clk); n++; end
    chk(done_t == 1'b1, "R10 short instance done", done_t, 1);
    chk(terr_t == 1'b1, "R10 timeout flagged", terr_t, 1);
    chk(result_t == 8'h6B && !ferr_t, "R6 result on fast clock", result_t, 8'h6B);
    chk(got_t[23:16] == exp_cmd(3'd5, 1'b1, 1'b1) && rises_t == 24, "R3 R5 fast frame",
        got_t[23:16], exp_cmd(3'd5, 1'b1, 1'b1));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule